// File: doc/BRIEF.md
# Fixed-Stride Microprogram Sequencer

This block is the control heart of a microprogrammed processor. It holds a writable control store of microwords and a microprogram counter that addresses it. The microword being read steers the sequencer itself. One flag captures the next machine opcode from the data bus into an instruction register. Another flag loads the counter with the start of that opcode's microroutine.

Each start address is the opcode with four zero bits appended. Every opcode therefore owns an aligned slot of sixteen microwords, and 256 opcodes share a 4096-word store. A routine that needs more than sixteen steps runs straight on into the next slot; nothing checks for or stops this.

The control store is filled through a plain write port, normally while reset is held. Reading is combinational, so the microword for the current address is on the output in the same cycle. There is no handshake at any edge of the block. The opcode is taken whenever the microword asks for it, so the bus source must hold the opcode valid during that cycle; there is no back-pressure.

Top module: `sq_fixed_stride_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the microaddress becomes 0 and the instruction register becomes 0. After reset, a counter load with no prior opcode capture therefore goes to address 0.
- R2: When microword bit 1 (counter load) is 0, `uaddr` advances by exactly one at each clock edge.
- R3: When microword bit 0 (opcode capture) is 1, the instruction register takes `data_bus` at that clock edge.
- R4: When microword bit 1 is 1, the next `uaddr` is the instruction register in bits 11:4, with bits 3:0 equal to zero.
- R5: When bits 0 and 1 are both set in one microword, the counter loads from the instruction register value held before that edge. The newly captured opcode is used only by a later counter load.
- R6: A routine that steps past offset 15 of its slot continues at offset 0 of the following slot, for example 0x0AF to 0x0B0.
- R7: Incrementing from 0xFFF wraps the microaddress to 0x000.
- R8: `uword` always equals the control store word at `uaddr`. A write lands at the clock edge, and its new data is visible on the next read of that address.
- R9: When bit 0 is 0, `data_bus` has no effect on the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| data_bus | input | OP_W (8) | Machine instruction opcode source |
| cs_we | input | 1 | Control store write enable |
| cs_waddr | input | OP_W+SLOT_W (12) | Control store write address |
| cs_wdata | input | UW_W (16) | Control store write data |
| uword | output | UW_W (16) | Microword at the current microaddress |
| uaddr | output | OP_W+SLOT_W (12) | Current microaddress |

## Verification
The sharpest corner is a microword that both captures an opcode and loads the counter. A design that forwards the bus straight into the counter would jump to the new opcode's slot instead of the old one. The bench also checks that reset really clears the opcode: if it did not, a load right after reset would land in a stale slot rather than at 0. It then runs a routine across a slot boundary and across the top of the address space, where a counter that saturates, or is too narrow, would stall or skip. It also changes the bus while capture is off; a design that leaks the bus into the instruction register would send a later counter load to the wrong slot.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Microword flag positions decoded by the sequencer itself
  localparam int unsigned IRLD_BIT = 0;
  localparam int unsigned PCLD_BIT = 1;
  localparam int unsigned FLAG_CNT = 2;
endpackage

// File: rtl/sq_instr_reg.sv
module sq_instr_reg #(
  parameter int unsigned OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap,
  input  logic [OP_W-1:0] din,
  output logic [OP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= din;
  end

  // R3
  ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (q == $past(din)));

  // R9
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q));
endmodule

// File: rtl/sq_upc.sv
module sq_upc #(
  parameter int unsigned OP_W   = 8,
  parameter int unsigned SLOT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld,
  input  logic [OP_W-1:0]        op,
  output logic [OP_W+SLOT_W-1:0] q
);
  localparam int unsigned ADDR_W = OP_W + SLOT_W;

  logic [ADDR_W-1:0] start_addr;
  assign start_addr = {op, {SLOT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= start_addr;
    else         q <= q + 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (q == ADDR_W'($past(q) + 1'b1)));

  // R4
  slot_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q[SLOT_W-1:0] == '0 && q[ADDR_W-1:SLOT_W] == $past(op)));
endmodule

// File: rtl/sq_ctrl_store.sv
module sq_ctrl_store #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned UW_W   = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [UW_W-1:0]   wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [UW_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [UW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R8
  write_visible_chk: assert property (@(posedge clk)
    (we && raddr == waddr) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sq_fixed_stride_seq.sv
module sq_fixed_stride_seq #(
  parameter int unsigned OP_W   = 8,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned UW_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [OP_W-1:0]        data_bus,
  input  logic                   cs_we,
  input  logic [OP_W+SLOT_W-1:0] cs_waddr,
  input  logic [UW_W-1:0]        cs_wdata,
  output logic [UW_W-1:0]        uword,
  output logic [OP_W+SLOT_W-1:0] uaddr
);
  import sq_pkg::*;

  localparam int unsigned ADDR_W = OP_W + SLOT_W;

  logic [OP_W-1:0] ir_q;
  logic            ir_cap;
  logic            pc_ld;

  assign ir_cap = uword[IRLD_BIT];
  assign pc_ld  = uword[PCLD_BIT];

  sq_instr_reg #(.OP_W(OP_W)) u_ir (
    .clk (clk),
    .rst (rst),
    .cap (ir_cap),
    .din (data_bus),
    .q   (ir_q)
  );

  sq_upc #(.OP_W(OP_W), .SLOT_W(SLOT_W)) u_pc (
    .clk (clk),
    .rst (rst),
    .ld  (pc_ld),
    .op  (ir_q),
    .q   (uaddr)
  );

  sq_ctrl_store #(.ADDR_W(ADDR_W), .UW_W(UW_W)) u_cs (
    .clk   (clk),
    .we    (cs_we),
    .waddr (cs_waddr),
    .wdata (cs_wdata),
    .raddr (uaddr),
    .rdata (uword)
  );

  // R5
  settled_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (ir_cap && pc_ld) |=> (uaddr[ADDR_W-1:SLOT_W] == $past(ir_q)));
endmodule

// File: tb/sim_sq_fixed_stride_seq.sv
module sim_sq_fixed_stride_seq;
  localparam int OP_W = 8;
  localparam int SLOT_W = 4;
  localparam int UW_W = 16;
  localparam int AW = OP_W + SLOT_W;
  localparam logic [1:0] F_IR = 2'b01, F_PC = 2'b10, F_BOTH = 2'b11, F_NONE = 2'b00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OP_W-1:0] data_bus = '0;
  logic cs_we = 1'b0;
  logic [AW-1:0] cs_waddr = '0;
  logic [UW_W-1:0] cs_wdata = '0;
  logic [UW_W-1:0] uword;
  logic [AW-1:0] uaddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sq_fixed_stride_seq #(.OP_W(OP_W), .SLOT_W(SLOT_W), .UW_W(UW_W)) u0 (
    .clk(clk), .rst(rst), .data_bus(data_bus), .cs_we(cs_we),
    .cs_waddr(cs_waddr), .cs_wdata(cs_wdata), .uword(uword), .uaddr(uaddr)
  );

  function automatic logic [UW_W-1:0] mk(input logic [13:0] tag, input logic [1:0] fl);
    return {tag, fl};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input logic [UW_W-1:0] d);
    cs_we = 1'b1; cs_waddr = AW'(a); cs_wdata = d;
    tick();
    cs_we = 1'b0;
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    tick();
    tick();
  endtask

  task automatic go();
    rst = 1'b0;
    #1;
  endtask

  // R1 R3 R4 R8 R2
  task automatic t_basic();
    hold_reset();
    wr(0, mk(14'h101, F_IR));
    wr(1, mk(14'h102, F_PC));
    wr('h3C0, mk(14'h2FB, F_NONE));
    wr('h3C1, mk(14'h2FC, F_NONE));
    data_bus = 8'h3C;
    go();
    check("R1 reset address", int'(uaddr), 0);
    check("R8 word at 0", int'(uword), int'(mk(14'h101, F_IR)));
    tick();
    check("R2 step to 1", int'(uaddr), 1);
    tick();
    check("R4 slot load 0x3C0", int'(uaddr), 'h3C0);
    check("R8 word at 0x3C0", int'(uword), int'(mk(14'h2FB, F_NONE)));
    tick();
    check("R2 step in slot", int'(uaddr), 'h3C1);
  endtask

  // R5
  task automatic t_same_cycle();
    hold_reset();
    wr(0, mk(14'h0, F_IR));
    wr(1, mk(14'h0, F_BOTH));
    wr('h120, mk(14'h0, F_PC));
    wr('h550, mk(14'h0, F_NONE));
    data_bus = 8'h12;
    go();
    tick();
    data_bus = 8'h55;
    #1;
    tick();
    check("R5 load uses settled opcode", int'(uaddr), 'h120);
    tick();
    check("R5 new opcode used later", int'(uaddr), 'h550);
  endtask

  // R9
  task automatic t_bus_ignored();
    hold_reset();
    wr(0, mk(14'h0, F_IR));
    wr(1, mk(14'h0, F_NONE));
    wr(2, mk(14'h0, F_PC));
    wr('h210, mk(14'h0, F_NONE));
    data_bus = 8'h21;
    go();
    tick();
    data_bus = 8'h99;
    #1;
    tick();
    data_bus = 8'hAA;
    #1;
    tick();
    check("R9 bus ignored without capture", int'(uaddr), 'h210);
  endtask

  // R1 instruction register cleared
  task automatic t_reset_ir();
    hold_reset();
    wr(0, mk(14'h0, F_IR));
    wr(1, mk(14'h0, F_NONE));
    data_bus = 8'h44;
    go();
    tick();
    hold_reset();
    wr(0, mk(14'h0, F_PC));
    data_bus = 8'h00;
    go();
    tick();
    check("R1 opcode cleared by reset", int'(uaddr), 0);
  endtask

  // R6
  task automatic t_overrun();
    hold_reset();
    wr(0, mk(14'h0, F_IR));
    wr(1, mk(14'h0, F_PC));
    for (int a = 'h0A0; a <= 'h0B2; a++) wr(a, mk(14'(a), F_NONE));
    data_bus = 8'h0A;
    go();
    tick();
    tick();
    check("R6 start of slot", int'(uaddr), 'h0A0);
    for (int i = 0; i < 15; i++) tick();
    check("R6 last slot offset", int'(uaddr), 'h0AF);
    tick();
    check("R6 runs into next slot", int'(uaddr), 'h0B0);
    check("R8 word after overrun", int'(uword), int'(mk(14'h0B0, F_NONE)));
  endtask

  // R7
  task automatic t_wrap();
    hold_reset();
    wr(0, mk(14'h0, F_IR));
    wr(1, mk(14'h0, F_PC));
    for (int a = 'hFF0; a <= 'hFFF; a++) wr(a, mk(14'h0, F_NONE));
    data_bus = 8'hFF;
    go();
    tick();
    tick();
    check("R7 top slot", int'(uaddr), 'hFF0);
    for (int i = 0; i < 15; i++) tick();
    check("R7 last address", int'(uaddr), 'hFFF);
    tick();
    check("R7 wrap to zero", int'(uaddr), 0);
  endtask

  // R8 write while running
  task automatic t_live_write();
    hold_reset();
    for (int a = 0; a < 6; a++) wr(a, mk(14'h0, F_NONE));
    go();
    cs_we = 1'b1; cs_waddr = AW'(2); cs_wdata = mk(14'h1A5, F_NONE);
    tick();
    cs_we = 1'b0;
    check("R2 step during write", int'(uaddr), 1);
    tick();
    check("R8 written word read back", int'(uword), int'(mk(14'h1A5, F_NONE)));
  endtask

  initial begin
    t_basic();
    t_same_cycle();
    t_bus_ignored();
    t_reset_ir();
    t_overrun();
    t_wrap();
    t_live_write();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule